// File: doc/BRIEF.md
# Colour Subcarrier Phase Accumulator

This block is the numerically controlled oscillator behind the chroma path of a video encoder. It holds a 32-bit phase word. On every pixel-clock cycle in which the advance enable is high, it adds a 32-bit frequency increment to that word. The increment equals round(f_subcarrier / f_pixel × 2^32). The upper phase bits address a sine/cosine table outside this block, and the top two bits give the quadrant of the carrier.

Software loads the increment one byte at a time. The four bytes collect in a staging word. The whole staging word becomes the live increment in one step when a line-start pulse arrives, so the accumulator never adds a half-written value. Typical words are 0x21F07C1F for 525-line NTSC at 1716 clocks per line, 0x2A098ACB for 625-line PAL at 1728 clocks per line, and 0x28A33BB2 for the other 1728-clock standard.

A field-start pulse marks each field. The block counts fields and clears the phase at the first field of every sequence. A sequence is either eight fields or four fields long, depending on a mode input, so the subcarrier stays in a fixed relation to the field sequence.

Top module: `sc_phase_acc`

## Requirements
- R1: After reset the phase word is 0, the live and staged increments are both 0x21F07C1F, and the field counter stands at the first field of a sequence.
- R2: On each rising clock edge with `pix_en` high and no phase clear, the phase becomes (phase + live increment) mod 2^32. With `pix_en` low and no clear, the phase holds.
- R3: A write with `wr_en` high places `wr_data` into staging byte `wr_sel`. Byte 3 holds bits 31:24 and byte 0 holds bits 7:0. The live increment does not change until a later `line_start`.
- R4: On an edge with `line_start` high, all 32 staged bits become the live increment together. The advance on that same edge still uses the old increment. A byte written on that same edge waits for the next `line_start`.
- R5: With `seq_mode` = 0, a `field_start` pulse clears the phase when it is the 1st, 9th, 17th, … pulse since reset, which is once every eight fields.
- R6: With `seq_mode` = 1, a `field_start` pulse clears the phase when the field counter (modulo 8) is a multiple of 4, which is once every four fields.
- R7: A clear takes priority over the advance: the phase is 0 after the edge that samples the selected `field_start`.
- R8: `lut_addr` equals phase bits 31:22 and `quadrant` equals phase bits 31:30.
- R9: The accumulator wraps modulo 2^32 without saturating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Advance enable for the accumulator |
| wr_en | input | 1 | Staging byte write strobe |
| wr_sel | input | 2 | Staging byte index (3 = most significant) |
| wr_data | input | 8 | Byte to stage |
| line_start | input | 1 | Commits the staged increment |
| field_start | input | 1 | One pulse per field |
| seq_mode | input | 1 | 0 = eight-field sequence, 1 = four-field sequence |
| phase | output | 32 | Accumulated phase word |
| lut_addr | output | 10 | Sine/cosine table address |
| quadrant | output | 2 | Carrier quadrant |

## Verification
Every result is due one register stage after the edge that samples its cause. The phase reflects an advance or a clear right after that edge. A committed increment first shows in the phase step of the edge after the commit. A staged byte first shows one edge after the commit that follows it. The bench drives inputs well before an edge and updates its reference model right after the edge using those same inputs. It compares the outputs 1 ns later, so each expectation lands in exactly the cycle the requirement names.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic {
    SEQ_EIGHT = 1'b0,
    SEQ_FOUR  = 1'b1
  } seq_len_e;
endpackage

// File: rtl/sc_inc_stage.sv
module sc_inc_stage #(
  parameter int            W       = 32,
  parameter int            BW      = 8,
  parameter logic [W-1:0]  RST_INC = 32'h21F07C1F,
  localparam int           NB      = W / BW,
  localparam int           SW      = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [BW-1:0] wr_data,
  input  logic          commit,
  output logic [W-1:0]  inc_act
);
  logic [W-1:0] stg_q, stg_d;
  logic [W-1:0] act_q, act_d;

  // staging word: one byte lane replaced per write
  always_comb begin
    stg_d = stg_q;
    for (int b = 0; b < NB; b++) begin
      if (wr_en && (wr_sel == SW'(b)))
        stg_d[b*BW +: BW] = wr_data;
    end
  end

  // live word: whole staging word taken at once
  always_comb begin
    act_d = act_q;
    if (commit)
      act_d = stg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= RST_INC;
      act_q <= RST_INC;
    end else begin
      stg_q <= stg_d;
      act_q <= act_d;
    end
  end

  assign inc_act = act_q;
endmodule

// File: rtl/sc_field_seq.sv
module sc_field_seq
  import sc_pkg::*;
#(
  parameter int LONG  = 8,
  parameter int SHORT = 4,
  localparam int CW   = $clog2(LONG)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     field_start,
  input  seq_len_e seq_len,
  output logic     seq_hit
);
  localparam logic [CW-1:0] LAST  = CW'(LONG - 1);
  localparam logic [CW-1:0] SMASK = CW'(SHORT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          first_of_seq;

  always_comb begin
    if (seq_len == SEQ_FOUR)
      first_of_seq = ((cnt_q & SMASK) == '0);
    else
      first_of_seq = (cnt_q == '0);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (field_start)
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign seq_hit = field_start && first_of_seq;
endmodule

// File: rtl/sc_phase_reg.sv
module sc_phase_reg #(
  parameter int W     = 32,
  parameter int LUT_W = 10,
  parameter int Q_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic             clr,
  input  logic [W-1:0]     inc,
  output logic [W-1:0]     phase,
  output logic [LUT_W-1:0] lut_addr,
  output logic [Q_W-1:0]   quad
);
  logic [W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (clr)
      ph_d = '0;
    else if (adv_en)
      ph_d = ph_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign phase    = ph_q;
  assign lut_addr = ph_q[W-1 -: LUT_W];
  assign quad     = ph_q[W-1 -: Q_W];
endmodule

// File: rtl/sc_phase_acc.sv
module sc_phase_acc
  import sc_pkg::*;
#(
  parameter int           PHASE_W = 32,
  parameter int           BYTE_W  = 8,
  parameter int           LUT_W   = 10,
  parameter int           QUAD_W  = 2,
  parameter int           SEQ_LONG  = 8,
  parameter int           SEQ_SHORT = 4,
  parameter logic [31:0]  RST_INC = 32'h21F07C1F,
  localparam int          NBYTES  = PHASE_W / BYTE_W,
  localparam int          SEL_W   = $clog2(NBYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_en,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic               line_start,
  input  logic               field_start,
  input  logic               seq_mode,
  output logic [PHASE_W-1:0] phase,
  output logic [LUT_W-1:0]   lut_addr,
  output logic [QUAD_W-1:0]  quadrant
);
  logic [PHASE_W-1:0] inc_act;
  logic               seq_hit;
  seq_len_e           seq_len;

  assign seq_len = seq_len_e'(seq_mode);

  sc_inc_stage #(
    .W(PHASE_W), .BW(BYTE_W), .RST_INC(RST_INC[PHASE_W-1:0])
  ) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .commit(line_start), .inc_act(inc_act)
  );

  sc_field_seq #(.LONG(SEQ_LONG), .SHORT(SEQ_SHORT)) u_seq (
    .clk(clk), .rst_n(rst_n), .field_start(field_start),
    .seq_len(seq_len), .seq_hit(seq_hit)
  );

  sc_phase_reg #(.W(PHASE_W), .LUT_W(LUT_W), .Q_W(QUAD_W)) u_ph (
    .clk(clk), .rst_n(rst_n), .adv_en(pix_en), .clr(seq_hit),
    .inc(inc_act), .phase(phase), .lut_addr(lut_addr), .quad(quadrant)
  );
endmodule

// File: rtl/sc_phase_acc_chk.sv
module sc_phase_acc_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pix_en,
  input logic         line_start,
  input logic         field_start,
  input logic         seq_hit,
  input logic [W-1:0] inc_act,
  input logic [W-1:0] phase
);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !seq_hit) |=> (phase == $past(phase) + $past(inc_act)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en && !seq_hit) |=> $stable(phase));

  a_r4_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(inc_act));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    seq_hit |=> (phase == '0));

  a_r5_hit_on_field: assert property (@(posedge clk) disable iff (!rst_n)
    seq_hit |-> field_start);
endmodule

bind sc_phase_acc sc_phase_acc_chk #(.W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
  .field_start(field_start), .seq_hit(seq_hit), .inc_act(inc_act),
  .phase(phase)
);

// File: tb/sim_sc_phase_acc.sv
`timescale 1ns/1ps
module sim_sc_phase_acc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_en, wr_en, line_start, field_start, seq_mode;
  logic [1:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [31:0] phase;
  logic [9:0]  lut_addr;
  logic [1:0]  quadrant;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_phase, m_inc, m_stage;
  int          m_fcnt;
  int          wraps;

  always #2 clk = ~clk;

  sc_phase_acc u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .line_start(line_start),
    .field_start(field_start), .seq_mode(seq_mode), .phase(phase),
    .lut_addr(lut_addr), .quadrant(quadrant)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model after posedge, compare 1 ns later
  task automatic cyc(input string req, input logic pe, input logic ls,
                     input logic fs, input logic we, input logic [1:0] sel,
                     input logic [7:0] dat);
    logic [31:0] old;
    bit hit;
    @(negedge clk);
    pix_en = pe; line_start = ls; field_start = fs;
    wr_en = we; wr_sel = sel; wr_data = dat;
    @(posedge clk);
    #1;
    hit = 0;
    if (fs) begin
      hit = seq_mode ? ((m_fcnt % 4) == 0) : (m_fcnt == 0);
      m_fcnt = (m_fcnt + 1) % 8;
    end
    old = m_phase;
    if (hit)      m_phase = 0;
    else if (pe)  m_phase = m_phase + m_inc;
    if (pe && !hit && (m_phase < old)) wraps++;
    if (ls) m_inc = m_stage;
    if (we) m_stage[sel*8 +: 8] = dat;
    chk(req, phase, m_phase);
    chk("R8", {22'd0, lut_addr}, {22'd0, m_phase[31:22]});
    chk("R8", {30'd0, quadrant}, {30'd0, m_phase[31:30]});
  endtask

  task automatic write_word(input string req, input logic [31:0] w);
    for (int b = 3; b >= 0; b--)
      cyc(req, 1'b1, 1'b0, 1'b0, 1'b1, 2'(b), w[b*8 +: 8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_en = 0; wr_en = 0; line_start = 0; field_start = 0;
    seq_mode = 0; wr_sel = 0; wr_data = 0;
    m_phase = 0; m_inc = 32'h21F07C1F; m_stage = 32'h21F07C1F; m_fcnt = 0; wraps = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", phase, 32'h0);

    // R1/R2: reset increment, advance and hold
    for (int i = 0; i < 6; i++) cyc("R1", 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc("R2", 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R2", 1, 0, 0, 0, 0, 0);

    // R3: staged bytes have no effect yet
    write_word("R3", 32'h2A098ACB);
    for (int i = 0; i < 3; i++) cyc("R3", 1, 0, 0, 0, 0, 0);
    // R4: commit, then new step
    cyc("R4", 1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc("R4", 1, 0, 0, 0, 0, 0);
    // R4: write on the commit edge waits
    cyc("R4", 1, 1, 0, 1, 2'd3, 8'hF0);
    for (int i = 0; i < 3; i++) cyc("R4", 1, 0, 0, 0, 0, 0);
    cyc("R4", 1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R4", 1, 0, 0, 0, 0, 0);

    // R9: wrap-around with another standard word
    write_word("R9", 32'h28A33BB2);
    cyc("R9", 1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) cyc("R9", 1, 0, 0, 0, 0, 0);
    checks++;
    if (wraps < 2) begin
      errors++;
      $display("FAIL R9 actual=%0d expected>=2 wraps", wraps);
    end

    // R5/R7: eight-field sequence, clear beats advance
    seq_mode = 0;
    for (int f = 0; f < 18; f++) begin
      cyc("R5", 1, 0, 1, 0, 0, 0);
      for (int i = 0; i < 3; i++) cyc("R7", 1, 0, 0, 0, 0, 0);
    end

    // R6: four-field sequence
    seq_mode = 1;
    for (int f = 0; f < 12; f++) begin
      cyc("R6", 1, 0, 1, 0, 0, 0);
      for (int i = 0; i < 2; i++) cyc("R6", 1, 0, 0, 0, 0, 0);
    end
    // R7: clear with advance disabled also yields zero
    for (int f = 0; f < 4; f++) cyc("R7", 0, 0, 1, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule